// File: doc/BRIEF.md
# Indirect Register Access Handshake Master

This block is the requesting side of a narrow indirect-access link into a 16-bit internal register space. The link has a 16-bit value field driven towards the far end, four strobes (address capture, data capture, read, write), and, coming back, an acknowledge bit plus a 16-bit result field. A client hands the block one command at a time: a direction flag, a 16-bit target address and, for writes, a 16-bit value. The block splits the command into phases and runs each one as a full four-phase exchange with the far end. It then reports completion, an error flag and, for reads, the returned word.

Every phase works the same way. The value is placed on the link for one cycle with all strobes low. The phase's strobe is then raised while the value is held, and the block waits for acknowledge to go high. The whole link is then driven to zero, and the block waits for acknowledge to go low again. A read has two phases: address capture, then the read strobe. A write has three: address capture, data capture, then the write strobe. Each wait is bounded by a parameterised cycle budget. If a wait runs past that budget, the access is abandoned and reported with an error.

Commands arrive on a valid/ready interface. The client holds `cmd_valid` and the command fields steady until a rising clock edge at which `cmd_ready` is also high. `cmd_ready` is low for the whole of an access, so the client is back-pressured until the last acknowledge-low of that access has been seen. Results leave as a one-cycle `rsp_done` pulse. The result interface has no back-pressure.

Top module: `regbridge_master`

## Requirements
- R1: A command is taken at a rising edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` is low from the cycle after acceptance until the access has completed, and is high whenever `rsp_done` is high. A command held valid while the block is busy is not taken until the running access is done, and its fields do not affect that running access.
- R2: Each phase first drives its value on `link_din` for at least one cycle with all strobes low. It then raises its strobe and keeps `link_din` unchanged while the strobe is high. Address and data phases carry the address or write value; read and write phases carry zero.
- R3: At most one of the four strobes is high in any cycle.
- R4: In the cycle after a strobe is seen together with `link_ack` high, every strobe is low and `link_din` is zero. No new strobe is raised until `link_ack` has been seen low.
- R5: A read consists of an address-capture phase followed by a read-strobe phase. `rsp_rdata` takes the value of `link_dout` sampled while `link_ack` is high during the read phase.
- R6: A write consists, in this order, of an address-capture phase, a data-capture phase and a write-strobe phase.
- R7: Each wait, for acknowledge high and then for acknowledge low, succeeds if the wanted level is present at one of the first `TIMEOUT_CYC` rising edges after the strobe (or the clear) appears on the link. Otherwise the access is abandoned, the link returns to zero, no later phase of that access is issued, and `rsp_error` is high with `rsp_done`.
- R8: A read that is abandoned in any phase returns 16'hFFFF on `rsp_rdata`. A write that is abandoned leaves `rsp_rdata` unchanged.
- R9: `rsp_done` is high for exactly one cycle per access. `rsp_error` is high only together with `rsp_done`. `rsp_rdata` changes only in a cycle where `rsp_done` is high and otherwise holds its value.
- R10: After reset, `cmd_ready` is high, all strobes, `link_din`, `rsp_done` and `rsp_error` are low, and `rsp_rdata` is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Block can take a command |
| cmd_write | input | 1 | 1 = write, 0 = read |
| cmd_addr | input | 16 | Target register address |
| cmd_wdata | input | 16 | Value for a write |
| rsp_done | output | 1 | One-cycle pulse at the end of an access |
| rsp_error | output | 1 | Access abandoned on a timeout (with rsp_done) |
| rsp_rdata | output | 16 | Read result, held until the next read or abandoned read completes |
| link_din | output | 16 | Value field towards the far end |
| link_addr_stb | output | 1 | Address-capture strobe |
| link_data_stb | output | 1 | Data-capture strobe |
| link_rd_stb | output | 1 | Read strobe |
| link_wr_stb | output | 1 | Write strobe |
| link_ack | input | 1 | Far-end acknowledge |
| link_dout | input | 16 | Far-end result field |

## Verification
The bench sweeps all 16 slots of a modelled far-end register file with writes and reads under varying acknowledge delays. A wrong address or data latch, or a missing setup cycle, returns words that differ from the computed ones. The acknowledge delay is set to exactly the last allowed edge and to one edge past it, for both the rise and the fall. An off-by-one in the timeout counter turns one of these into a wrong error flag. The far end is also made silent in each single phase. A block that carries on after an abandoned phase either commits a write that should not exist or returns stale data in place of all ones. A second command held valid during an access checks that back-pressure keeps the running access intact.

// File: rtl/regbridge_pkg.sv
package regbridge_pkg;

  // Phase kinds; the value is also the strobe bit index on the link.
  typedef enum logic [1:0] {
    PH_ADDR  = 2'd0,
    PH_DATA  = 2'd1,
    PH_READ  = 2'd2,
    PH_WRITE = 2'd3
  } phase_e;

  localparam int unsigned NUM_STB = 4;

  function automatic logic [NUM_STB-1:0] phase_strobe(input phase_e k);
    logic [NUM_STB-1:0] v;
    v = '0;
    v[k] = 1'b1;
    return v;
  endfunction

endpackage

// File: rtl/regbridge_timer.sv
module regbridge_timer #(
  parameter int unsigned LIMIT = 1024,
  localparam int unsigned CNT_W = $clog2(LIMIT + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  logic [CNT_W-1:0] cnt_q;

  assign expired = run && (cnt_q == CNT_W'(LIMIT - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (!run || expired) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/regbridge_phase_hs.sv
module regbridge_phase_hs
  import regbridge_pkg::*;
#(
  parameter int unsigned W     = 16,
  parameter int unsigned LIMIT = 1024
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               start,
  input  phase_e             kind,
  input  logic [W-1:0]       value,
  input  logic               ack,
  input  logic [W-1:0]       dout,
  output logic [W-1:0]       din,
  output logic [NUM_STB-1:0] stb,
  output logic               fin,
  output logic               tmo,
  output logic [W-1:0]       cap
);
  typedef enum logic [1:0] {HS_IDLE, HS_SETUP, HS_RAISE, HS_DROP} hs_e;

  hs_e    st_q;
  phase_e kind_q;
  logic   run;
  logic   expired;

  // The timer runs only while the wanted acknowledge level is missing.
  assign run = ((st_q == HS_RAISE) && !ack) || ((st_q == HS_DROP) && ack);

  regbridge_timer #(.LIMIT(LIMIT)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (run),
    .expired (expired)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= HS_IDLE;
      kind_q <= PH_ADDR;
      din    <= '0;
      stb    <= '0;
      fin    <= 1'b0;
      tmo    <= 1'b0;
      cap    <= '0;
    end else begin
      fin <= 1'b0;
      tmo <= 1'b0;
      unique case (st_q)
        HS_IDLE: begin
          if (start) begin
            kind_q <= kind;
            din    <= value;
            stb    <= '0;
            st_q   <= HS_SETUP;
          end
        end
        HS_SETUP: begin
          stb  <= phase_strobe(kind_q);
          st_q <= HS_RAISE;
        end
        HS_RAISE: begin
          if (ack) begin
            cap  <= dout;
            din  <= '0;
            stb  <= '0;
            st_q <= HS_DROP;
          end else if (expired) begin
            din  <= '0;
            stb  <= '0;
            fin  <= 1'b1;
            tmo  <= 1'b1;
            st_q <= HS_IDLE;
          end
        end
        HS_DROP: begin
          if (!ack) begin
            fin  <= 1'b1;
            st_q <= HS_IDLE;
          end else if (expired) begin
            fin  <= 1'b1;
            tmo  <= 1'b1;
            st_q <= HS_IDLE;
          end
        end
        default: st_q <= HS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/regbridge_access_seq.sv
module regbridge_access_seq
  import regbridge_pkg::*;
#(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         cmd_valid,
  output logic         cmd_ready,
  input  logic         cmd_write,
  input  logic [W-1:0] cmd_addr,
  input  logic [W-1:0] cmd_wdata,
  output logic         hs_start,
  output phase_e       hs_kind,
  output logic [W-1:0] hs_value,
  input  logic         hs_fin,
  input  logic         hs_tmo,
  input  logic [W-1:0] hs_cap,
  output logic         rsp_done,
  output logic         rsp_error,
  output logic [W-1:0] rsp_rdata
);
  typedef enum logic [1:0] {SQ_IDLE, SQ_ADDR, SQ_DATA, SQ_CMD} sq_e;

  sq_e          st_q;
  logic         is_wr_q;
  logic [W-1:0] wdata_q;

  assign cmd_ready = (st_q == SQ_IDLE);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= SQ_IDLE;
      is_wr_q   <= 1'b0;
      wdata_q   <= '0;
      hs_start  <= 1'b0;
      hs_kind   <= PH_ADDR;
      hs_value  <= '0;
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      hs_start  <= 1'b0;
      rsp_done  <= 1'b0;
      rsp_error <= 1'b0;
      if (st_q == SQ_IDLE) begin
        if (cmd_valid) begin
          is_wr_q  <= cmd_write;
          wdata_q  <= cmd_wdata;
          hs_start <= 1'b1;
          hs_kind  <= PH_ADDR;
          hs_value <= cmd_addr;
          st_q     <= SQ_ADDR;
        end
      end else if (hs_fin) begin
        if (hs_tmo) begin
          rsp_done  <= 1'b1;
          rsp_error <= 1'b1;
          if (!is_wr_q) rsp_rdata <= '1;
          st_q <= SQ_IDLE;
        end else begin
          unique case (st_q)
            SQ_ADDR: begin
              hs_start <= 1'b1;
              if (is_wr_q) begin
                hs_kind  <= PH_DATA;
                hs_value <= wdata_q;
                st_q     <= SQ_DATA;
              end else begin
                hs_kind  <= PH_READ;
                hs_value <= '0;
                st_q     <= SQ_CMD;
              end
            end
            SQ_DATA: begin
              hs_start <= 1'b1;
              hs_kind  <= PH_WRITE;
              hs_value <= '0;
              st_q     <= SQ_CMD;
            end
            SQ_CMD: begin
              rsp_done <= 1'b1;
              if (!is_wr_q) rsp_rdata <= hs_cap;
              st_q <= SQ_IDLE;
            end
            default: st_q <= SQ_IDLE;
          endcase
        end
      end
    end
  end
endmodule

// File: rtl/regbridge_master.sv
module regbridge_master
  import regbridge_pkg::*;
#(
  parameter int unsigned DATA_W      = 16,
  parameter int unsigned TIMEOUT_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic              cmd_write,
  input  logic [DATA_W-1:0] cmd_addr,
  input  logic [DATA_W-1:0] cmd_wdata,
  output logic              rsp_done,
  output logic              rsp_error,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [DATA_W-1:0] link_din,
  output logic              link_addr_stb,
  output logic              link_data_stb,
  output logic              link_rd_stb,
  output logic              link_wr_stb,
  input  logic              link_ack,
  input  logic [DATA_W-1:0] link_dout
);
  logic               hs_start;
  phase_e             hs_kind;
  logic [DATA_W-1:0]  hs_value;
  logic               hs_fin;
  logic               hs_tmo;
  logic [DATA_W-1:0]  hs_cap;
  logic [NUM_STB-1:0] stb;

  regbridge_access_seq #(.W(DATA_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .cmd_valid (cmd_valid),
    .cmd_ready (cmd_ready),
    .cmd_write (cmd_write),
    .cmd_addr  (cmd_addr),
    .cmd_wdata (cmd_wdata),
    .hs_start  (hs_start),
    .hs_kind   (hs_kind),
    .hs_value  (hs_value),
    .hs_fin    (hs_fin),
    .hs_tmo    (hs_tmo),
    .hs_cap    (hs_cap),
    .rsp_done  (rsp_done),
    .rsp_error (rsp_error),
    .rsp_rdata (rsp_rdata)
  );

  regbridge_phase_hs #(.W(DATA_W), .LIMIT(TIMEOUT_CYC)) u_hs (
    .clk   (clk),
    .rst_n (rst_n),
    .start (hs_start),
    .kind  (hs_kind),
    .value (hs_value),
    .ack   (link_ack),
    .dout  (link_dout),
    .din   (link_din),
    .stb   (stb),
    .fin   (hs_fin),
    .tmo   (hs_tmo),
    .cap   (hs_cap)
  );

  assign link_addr_stb = stb[PH_ADDR];
  assign link_data_stb = stb[PH_DATA];
  assign link_rd_stb   = stb[PH_READ];
  assign link_wr_stb   = stb[PH_WRITE];
endmodule

// File: rtl/regbridge_checker.sv
module regbridge_checker #(
  parameter int unsigned DATA_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_ready,
  input logic              rsp_done,
  input logic              rsp_error,
  input logic [DATA_W-1:0] rsp_rdata,
  input logic [DATA_W-1:0] link_din,
  input logic              link_addr_stb,
  input logic              link_data_stb,
  input logic              link_rd_stb,
  input logic              link_wr_stb,
  input logic              link_ack
);
  logic [3:0] stbs;
  logic       any_stb;
  assign stbs    = {link_wr_stb, link_rd_stb, link_data_stb, link_addr_stb};
  assign any_stb = |stbs;

  assert_busy_not_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    any_stb |-> !cmd_ready);

  assert_done_ready_R1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> cmd_ready);

  assert_setup_din_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(any_stb) |-> $stable(link_din));

  assert_one_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(stbs) <= 1);

  assert_clear_after_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (any_stb && link_ack) |=> (!any_stb && (link_din == '0)));

  assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  assert_err_with_done_R9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_error |-> rsp_done);

  assert_rdata_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(rsp_rdata) |-> rsp_done);
endmodule

bind regbridge_master regbridge_checker #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .cmd_ready     (cmd_ready),
  .rsp_done      (rsp_done),
  .rsp_error     (rsp_error),
  .rsp_rdata     (rsp_rdata),
  .link_din      (link_din),
  .link_addr_stb (link_addr_stb),
  .link_data_stb (link_data_stb),
  .link_rd_stb   (link_rd_stb),
  .link_wr_stb   (link_wr_stb),
  .link_ack      (link_ack)
);

// File: tb/sim_regbridge_master.sv
`timescale 1ns/1ps
module sim_regbridge_master;
  localparam int TMO = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic        cmd_ready;
  logic        cmd_write = 1'b0;
  logic [15:0] cmd_addr = '0;
  logic [15:0] cmd_wdata = '0;
  logic        rsp_done, rsp_error;
  logic [15:0] rsp_rdata;
  logic [15:0] link_din;
  logic        link_addr_stb, link_data_stb, link_rd_stb, link_wr_stb;
  logic        link_ack;
  logic [15:0] link_dout;

  always #2.5 clk = ~clk;

  regbridge_master #(.DATA_W(16), .TIMEOUT_CYC(TMO)) u0 (
    .clk(clk), .rst_n(rst_n),
    .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
    .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
    .rsp_done(rsp_done), .rsp_error(rsp_error), .rsp_rdata(rsp_rdata),
    .link_din(link_din), .link_addr_stb(link_addr_stb), .link_data_stb(link_data_stb),
    .link_rd_stb(link_rd_stb), .link_wr_stb(link_wr_stb),
    .link_ack(link_ack), .link_dout(link_dout)
  );

  // ---------------- far-end model ----------------
  int          hi_lat = 1, lo_lat = 1;
  logic [3:0]  mute = 4'b0000;   // bit0 addr, bit1 data, bit2 read, bit3 write
  int          hi_cnt, lo_cnt;
  logic        ack_q;
  logic [15:0] dout_q, cap_addr, cap_data, prev_din;
  logic        prev_any, a_ok, d_ok;
  logic [15:0] mem [16];
  int          setup_err, multi_err, early_err, ord_err, accepts;
  logic [3:0]  stbv;
  logic        any;

  assign stbv = {link_wr_stb, link_rd_stb, link_data_stb, link_addr_stb};
  assign any = |stbv;
  assign link_ack = ack_q;
  assign link_dout = dout_q;

  always @(posedge clk) begin
    if (!rst_n) begin
      ack_q <= 1'b0; dout_q <= 16'h5A5A; hi_cnt <= 0; lo_cnt <= 0;
      cap_addr <= '0; cap_data <= '0; prev_din <= '0; prev_any <= 1'b0;
      a_ok <= 1'b0; d_ok <= 1'b0;
      setup_err <= 0; multi_err <= 0; early_err <= 0; ord_err <= 0; accepts <= 0;
      for (int i = 0; i < 16; i++) mem[i] <= '0;
    end else begin
      prev_din <= link_din;
      prev_any <= any;
      if (cmd_valid && cmd_ready) accepts <= accepts + 1;
      if (any && !prev_any && (link_din != prev_din)) setup_err <= setup_err + 1;
      if ($countones(stbv) > 1) multi_err <= multi_err + 1;
      if (any && !prev_any && ack_q) early_err <= early_err + 1;
      if (any && !ack_q) begin
        if ((stbv & mute) != 4'b0000) begin
        end else if (hi_cnt + 1 >= hi_lat) begin
          ack_q <= 1'b1; hi_cnt <= 0;
          if (link_addr_stb) begin
            cap_addr <= link_din; a_ok <= 1'b1; d_ok <= 1'b0;
          end else if (link_data_stb) begin
            if (!a_ok) ord_err <= ord_err + 1;
            cap_data <= link_din; d_ok <= 1'b1;
          end else if (link_rd_stb) begin
            if (!a_ok || d_ok) ord_err <= ord_err + 1;
            dout_q <= mem[cap_addr[3:0]] ^ cap_addr; a_ok <= 1'b0;
          end else begin
            if (!(a_ok && d_ok)) ord_err <= ord_err + 1;
            mem[cap_addr[3:0]] <= cap_data; a_ok <= 1'b0; d_ok <= 1'b0;
          end
        end else hi_cnt <= hi_cnt + 1;
      end else if (!any && ack_q) begin
        if (lo_cnt + 1 >= lo_lat) begin
          ack_q <= 1'b0; lo_cnt <= 0; dout_q <= ~dout_q;
        end else lo_cnt <= lo_cnt + 1;
      end else begin
        hi_cnt <= 0; lo_cnt <= 0;
      end
    end
  end

  // ---------------- checking ----------------
  int checks = 0, failures = 0, issued = 0;
  bit finished = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Runs one access; returns error flag and read data. Inputs driven on negedges.
  task automatic access(input bit wr, input logic [15:0] a, input logic [15:0] d,
                        output bit err, output logic [15:0] rd);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = wr; cmd_addr = a; cmd_wdata = d;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0; cmd_addr = 16'hBAD0; cmd_wdata = 16'hBAD1;
    issued++;
    chk(!cmd_ready, "R1 ready low after accept", {31'd0, cmd_ready}, 0);
    while (!rsp_done) @(negedge clk);
    err = rsp_error; rd = rsp_rdata;
    chk(cmd_ready, "R1 ready with done", {31'd0, cmd_ready}, 1);
    @(negedge clk);
    chk(!rsp_done && !rsp_error, "R9 done one cycle", {30'd0, rsp_done, rsp_error}, 0);
  endtask

  function automatic logic [15:0] addr_of(input int i);
    logic [3:0] n;
    n = i[3:0];
    return {n, ~n, n ^ 4'h5, n};
  endfunction

  function automatic logic [15:0] val_of(input int i, input int salt);
    return 16'(i * 16'h0713 + 16'h2468 + salt * 16'h1F01);
  endfunction

  initial begin
    int wd = 0;
    while (!finished && wd < 150000) begin @(posedge clk); wd++; end
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=%0d expected=done", wd);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit err;
    logic [15:0] rd, last_rd, old5;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk(cmd_ready && !any && link_din == 0 && !rsp_done && !rsp_error && rsp_rdata == 0,
        "R10 reset state", {cmd_ready, any, rsp_done, rsp_error, rsp_rdata, 12'd0}, 32'h8000_0000);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R6 / R5: sweep every slot, varying ack delays
    for (int i = 0; i < 16; i++) begin
      hi_lat = 1 + (i % 4); lo_lat = 1 + (i % 3);
      access(1'b1, addr_of(i), val_of(i, 0), err, rd);
      chk(!err, "R6 write ok", {31'd0, err}, 0);
      chk(rd == rsp_rdata && rd == 16'h0000, "R9 write keeps rdata", rd, 0);
    end
    for (int i = 0; i < 16; i++) begin
      hi_lat = 1 + ((i + 1) % 4); lo_lat = 1 + ((i + 2) % 3);
      access(1'b0, addr_of(i), 16'h0, err, rd);
      chk(!err && rd == (val_of(i, 0) ^ addr_of(i)), "R5 read data", {15'd0, err, rd},
          {16'd0, val_of(i, 0) ^ addr_of(i)});
    end
    last_rd = rd;
    access(1'b1, addr_of(2), val_of(2, 1), err, rd);
    chk(rsp_rdata == last_rd, "R9 rdata held over write", rsp_rdata, last_rd);

    // R7: acknowledge-high boundary
    hi_lat = TMO - 1; lo_lat = 1;
    access(1'b0, addr_of(2), 16'h0, err, rd);
    chk(!err && rd == (val_of(2, 1) ^ addr_of(2)), "R7 ack high at last edge", {15'd0, err, rd},
        {16'd0, val_of(2, 1) ^ addr_of(2)});
    hi_lat = TMO;
    access(1'b0, addr_of(3), 16'h0, err, rd);
    chk(err, "R7 ack high one edge late", {31'd0, err}, 1);
    chk(rd == 16'hFFFF, "R8 late address read all ones", rd, 16'hFFFF);
    hi_lat = 1; repeat (20) @(negedge clk);

    // R7: acknowledge-low boundary
    lo_lat = TMO - 1;
    access(1'b0, addr_of(4), 16'h0, err, rd);
    chk(!err && rd == (val_of(4, 0) ^ addr_of(4)), "R7 ack low at last edge", {15'd0, err, rd},
        {16'd0, val_of(4, 0) ^ addr_of(4)});
    lo_lat = TMO;
    access(1'b0, addr_of(4), 16'h0, err, rd);
    chk(err && rd == 16'hFFFF, "R7 ack low one edge late", {15'd0, err, rd}, 32'h1FFFF);
    lo_lat = 1; repeat (20) @(negedge clk);

    // R8: silent far end in each phase
    mute = 4'b0001;
    access(1'b0, addr_of(6), 16'h0, err, rd);
    chk(err && rd == 16'hFFFF, "R8 silent address read", {15'd0, err, rd}, 32'h1FFFF);
    mute = 4'b0100;
    access(1'b0, addr_of(6), 16'h0, err, rd);
    chk(err && rd == 16'hFFFF, "R8 silent read phase", {15'd0, err, rd}, 32'h1FFFF);
    mute = 4'b0010;
    access(1'b1, addr_of(7), 16'hAAAA, err, rd);
    chk(err && rd == 16'hFFFF, "R8 write abort keeps rdata", {15'd0, err, rd}, 32'h1FFFF);
    mute = 4'b1000;
    access(1'b1, addr_of(7), 16'hBBBB, err, rd);
    chk(err, "R7 silent write phase", {31'd0, err}, 1);
    mute = 4'b0000;
    access(1'b0, addr_of(7), 16'h0, err, rd);
    chk(!err && rd == (val_of(7, 0) ^ addr_of(7)), "R7 aborted writes not committed",
        {15'd0, err, rd}, {16'd0, val_of(7, 0) ^ addr_of(7)});

    // R1: command held valid while busy
    old5 = val_of(5, 3);
    @(negedge clk);
    cmd_valid = 1'b1; cmd_write = 1'b1; cmd_addr = addr_of(5); cmd_wdata = old5;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_write = 1'b0; cmd_addr = addr_of(5); cmd_wdata = 16'h0BAD;
    issued += 2;
    chk(!cmd_ready, "R1 busy back-pressure", {31'd0, cmd_ready}, 0);
    while (!rsp_done) @(negedge clk);
    chk(!rsp_error, "R1 first of pair ok", {31'd0, rsp_error}, 0);
    @(negedge clk);
    cmd_valid = 1'b0;
    chk(!cmd_ready, "R1 held command taken after done", {31'd0, cmd_ready}, 0);
    while (!rsp_done) @(negedge clk);
    chk(!rsp_error && rsp_rdata == (old5 ^ addr_of(5)), "R1 held read sees write",
        rsp_rdata, old5 ^ addr_of(5));
    repeat (4) @(negedge clk);
    chk(accepts == issued, "R1 accept count", accepts, issued);

    // Link protocol monitors
    chk(setup_err == 0, "R2 setup cycle and held value", setup_err, 0);
    chk(multi_err == 0, "R3 single strobe", multi_err, 0);
    chk(early_err == 0, "R4 no strobe before ack low", early_err, 0);
    chk(ord_err == 0, "R6 phase order", ord_err, 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule